// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a parallel flash device. It watches the chip-enable, write-enable and output-enable strobes, and it captures the address and data buses. It turns completed bus writes into command bytes. It keeps track of which read mode is active and which embedded operation is pending, running or suspended. When a program or erase sequence is complete, it starts the internal algorithm through a one-cycle start pulse. It also chooses what a bus read drives: array contents, identification words, the status byte, or the query table. The erase and program algorithms sit outside the block. They report back through a done/fail pair and pause when told to by two hold levels. The storage array also sits outside, and it supplies `array_rdata` for the address currently on the bus.

Commands have no address of their own: any address may carry a command byte. Program and erase are two-cycle sequences. Suspend nests in one direction only. An erase may be suspended. A program may then run inside that suspension and may itself be suspended. A resume always continues the innermost suspended operation first. All strobes are treated as sampled synchronously with `clk`.

Top module: `flash_cui`

## Requirements
- R1: While `rst` is high and after it falls, the block is in array-read mode, the status byte is 0x80, no operation is pending, and `op_start`, `hold_prog`, `hold_erase` and `dout_en` are low. No command is needed before array data is read.
- R2: A bus write is a cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1. It completes in the first cycle in which either `ce_n` or `we_n` has returned high. The address and data sampled in that cycle are the ones used. A low pulse of `ce_n` and `we_n` taken while `oe_n` is low is not a write.
- R3: One cycle after a sample with `ce_n`=0, `oe_n`=0 and `we_n`=1, `dout_en` is 1 and `dout` carries the selected word. After any other sample, `dout_en` is 0 and `dout` is 0.
- R4: Command byte (data bits 7:0) 0xFF selects array reads, which return `array_rdata`. 0x90 selects identification reads: `MFR_ID` when address bit 0 is 0, `DEV_ID` when it is 1. 0x70 selects status reads, which return the status byte in bits 7:0. 0x98 selects query reads: 0x51, 0x52 and 0x59 at address bits 7:0 = 0x10, 0x11 and 0x12, and 0 at every other address.
- R5: 0x40 or 0x10, accepted when nothing runs and no program exists, is followed by a second write. That second write raises `op_start` for one cycle with `op_is_erase`=0 and the second write's address and data on `op_addr` and `op_wdata`. The block then enters status reads.
- R6: 0x20, accepted when no program or erase exists, is followed by a second write. If the second write carries 0xD0, `op_start` rises with `op_is_erase`=1 and `op_addr` set to that write's address. Any other byte starts nothing, sets status bits 5 and 4, and leaves the block in status reads.
- R7: While a program or erase is running and not suspended, every read returns the status byte with bit 7 (ready) clear. Program and erase setup commands are ignored during that time.
- R8: An `op_done` pulse ends the running operation. If `op_fail` is high at the same time, status bit 4 is set for a program or bit 5 for an erase. 0x50 clears both bits. `op_done` has no effect when nothing is running.
- R9: 0xB0 suspends the running operation. A program raises `hold_prog` and status bit 2; an erase raises `hold_erase` and status bit 6. Bit 7 then reads 1. 0xD0 resumes the innermost suspended operation. While an erase is suspended, array reads may be selected.
- R10: During an erase suspension, a program may be set up, started and suspended in turn. Erase setup is ignored there. At most one operation runs at a time. The first 0xD0 resumes the program, and a later 0xD0 resumes the erase once the program has ended.
- R11: A command byte outside {0xFF, 0x90, 0x70, 0x98, 0x50, 0x40, 0x10, 0x20, 0xB0, 0xD0}, written with no setup pending, leaves the read mode and all state unchanged. The address of a command write has no effect.
- R12: After an operation ends, reads keep returning the status byte until 0xFF is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| din | input | DATA_W | Bus write data |
| array_rdata | input | DATA_W | Array word at `addr`, from the storage array |
| dout | output | DATA_W | Registered read data |
| dout_en | output | 1 | Registered output-driver enable |
| op_start | output | 1 | One-cycle start of an embedded operation |
| op_is_erase | output | 1 | Kind of the last started operation (1 = erase) |
| op_addr | output | ADDR_W | Address of the last started operation |
| op_wdata | output | DATA_W | Program data of the last started operation |
| op_done | input | 1 | Running operation finished |
| op_fail | input | 1 | Qualifies `op_done` as a failure |
| hold_prog | output | 1 | Program suspended; the engine must pause it |
| hold_erase | output | 1 | Erase suspended; the engine must pause it |

## Verification
The bench aims at the capture edge. It ends one write pulse by raising WE first and another by raising CE first. A design that captured the bus on the later edge, or on a pulse taken with OE low, would start operations with stale addresses or react to reads. It walks the full nested path: erase, suspend, program, suspend, then two resumes and two completions. A design that resumed the outer erase first, or let two operations run at once, would raise the wrong hold level and show the wrong status bits. It also covers a bad erase confirm, a completion strobe arriving with nothing running, and an unknown command byte. A wrong design would start an erase anyway, mark an error without cause, or drop the current read mode.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_HELD = 2'd2
  } op_phase_e;

  typedef enum logic [1:0] {
    SU_NONE  = 2'd0,
    SU_PROG  = 2'd1,
    SU_ERASE = 2'd2
  } setup_e;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_RD_IDENT = 8'h90;
  localparam logic [7:0] C_RD_STAT  = 8'h70;
  localparam logic [7:0] C_RD_QUERY = 8'h98;
  localparam logic [7:0] C_CLR_STAT = 8'h50;
  localparam logic [7:0] C_PROG     = 8'h40;
  localparam logic [7:0] C_PROG_ALT = 8'h10;
  localparam logic [7:0] C_ERASE    = 8'h20;
  localparam logic [7:0] C_SUSPEND  = 8'hB0;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;

  localparam logic [7:0] STATUS_RESET = 8'h80;

  // True for every byte the decoder reacts to outside a setup cycle.
  function automatic logic cmd_known(input logic [7:0] c);
    case (c)
      C_RD_ARRAY, C_RD_IDENT, C_RD_STAT, C_RD_QUERY, C_CLR_STAT,
      C_PROG, C_PROG_ALT, C_ERASE, C_SUSPEND, C_CONFIRM: cmd_known = 1'b1;
      default: cmd_known = 1'b0;
    endcase
  endfunction

  // Query table: the three signature characters, zero elsewhere.
  function automatic logic [7:0] query_byte(input logic [7:0] off);
    case (off)
      8'h10:   query_byte = 8'h51;
      8'h11:   query_byte = 8'h52;
      8'h12:   query_byte = 8'h59;
      default: query_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cui_bus_sampler.sv
module cui_bus_sampler #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              rd_req
);

  logic wr_phase_q;
  logic wr_phase_d;

  assign wr_phase_d = ~ce_n & ~we_n & oe_n;
  assign rd_req     = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk) begin
    if (rst) wr_phase_q <= 1'b0;
    else     wr_phase_q <= wr_phase_d;
  end

  // The write ends on the first strobe of the pair to return high.
  assign wr_evt   = wr_phase_q & (ce_n | we_n);
  assign cap_addr = addr;
  assign cap_data = din;

endmodule

// File: rtl/cui_cmd_fsm.sv
module cui_cmd_fsm
  import flash_cui_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              op_done,
  input  logic              op_fail,
  output rd_mode_e          rmode,
  output logic              busy,
  output logic [7:0]        status,
  output logic              setup_pend,
  output logic              prog_run,
  output logic              erase_run,
  output logic              op_start,
  output logic              op_is_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata,
  output logic              hold_prog,
  output logic              hold_erase
);

  rd_mode_e  mode_q, mode_d;
  setup_e    setup_q, setup_d;
  op_phase_e prog_q, prog_d;
  op_phase_e erase_q, erase_d;
  logic      perr_q, perr_d;
  logic      eerr_q, eerr_d;
  logic      start_d;
  logic      kind_d;

  logic [7:0] cmd;
  assign cmd = cap_data[7:0];

  assign prog_run   = (prog_q == PH_RUN);
  assign erase_run  = (erase_q == PH_RUN);
  assign busy       = prog_run | erase_run;
  assign setup_pend = (setup_q != SU_NONE);
  assign hold_prog  = (prog_q == PH_HELD);
  assign hold_erase = (erase_q == PH_HELD);
  assign rmode      = mode_q;

  assign status = {~busy, hold_erase, eerr_q, perr_q, 1'b0, hold_prog, 2'b00};

  always_comb begin
    mode_d  = mode_q;
    setup_d = setup_q;
    prog_d  = prog_q;
    erase_d = erase_q;
    perr_d  = perr_q;
    eerr_d  = eerr_q;
    start_d = 1'b0;
    kind_d  = op_is_erase;

    // Completion of the operation that owns the engine.
    if (op_done && busy) begin
      if (prog_run) begin
        prog_d = PH_IDLE;
        if (op_fail) perr_d = 1'b1;
      end else begin
        erase_d = PH_IDLE;
        if (op_fail) eerr_d = 1'b1;
      end
    end

    if (wr_evt) begin
      unique case (setup_q)
        SU_PROG: begin
          setup_d = SU_NONE;
          mode_d  = RM_STATUS;
          prog_d  = PH_RUN;
          start_d = 1'b1;
          kind_d  = 1'b0;
        end
        SU_ERASE: begin
          setup_d = SU_NONE;
          mode_d  = RM_STATUS;
          if (cmd == C_CONFIRM) begin
            erase_d = PH_RUN;
            start_d = 1'b1;
            kind_d  = 1'b1;
          end else begin
            perr_d = 1'b1;
            eerr_d = 1'b1;
          end
        end
        default: begin
          case (cmd)
            C_RD_ARRAY: mode_d = RM_ARRAY;
            C_RD_IDENT: mode_d = RM_IDENT;
            C_RD_STAT:  mode_d = RM_STATUS;
            C_RD_QUERY: mode_d = RM_QUERY;
            C_CLR_STAT: begin
              perr_d = 1'b0;
              eerr_d = 1'b0;
            end
            C_PROG, C_PROG_ALT: begin
              if (!busy && prog_q == PH_IDLE) begin
                setup_d = SU_PROG;
                mode_d  = RM_STATUS;
              end
            end
            C_ERASE: begin
              if (!busy && prog_q == PH_IDLE && erase_q == PH_IDLE) begin
                setup_d = SU_ERASE;
                mode_d  = RM_STATUS;
              end
            end
            C_SUSPEND: begin
              if (prog_run) begin
                prog_d = PH_HELD;
                mode_d = RM_STATUS;
              end else if (erase_run) begin
                erase_d = PH_HELD;
                mode_d  = RM_STATUS;
              end
            end
            C_CONFIRM: begin
              if (prog_q == PH_HELD) begin
                prog_d = PH_RUN;
                mode_d = RM_STATUS;
              end else if (erase_q == PH_HELD && prog_q == PH_IDLE) begin
                erase_d = PH_RUN;
                mode_d  = RM_STATUS;
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= RM_ARRAY;
      setup_q     <= SU_NONE;
      prog_q      <= PH_IDLE;
      erase_q     <= PH_IDLE;
      perr_q      <= 1'b0;
      eerr_q      <= 1'b0;
      op_start    <= 1'b0;
      op_is_erase <= 1'b0;
      op_addr     <= '0;
      op_wdata    <= '0;
    end else begin
      mode_q      <= mode_d;
      setup_q     <= setup_d;
      prog_q      <= prog_d;
      erase_q     <= erase_d;
      perr_q      <= perr_d;
      eerr_q      <= eerr_d;
      op_start    <= start_d;
      op_is_erase <= kind_d;
      if (start_d) begin
        op_addr  <= cap_addr;
        op_wdata <= cap_data;
      end
    end
  end

endmodule

// File: rtl/cui_read_mux.sv
module cui_read_mux
  import flash_cui_pkg::*;
#(
  parameter int              ADDR_W = 20,
  parameter int              DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h00C7,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h4A2E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] array_rdata,
  input  rd_mode_e          rmode,
  input  logic              busy,
  input  logic [7:0]        status,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  localparam int PAD_W = DATA_W - 8;

  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] query_word;
  logic [DATA_W-1:0] sel;

  assign stat_word  = {{PAD_W{1'b0}}, status};
  assign query_word = {{PAD_W{1'b0}}, query_byte(addr[7:0])};

  always_comb begin
    if (busy) begin
      sel = stat_word;
    end else begin
      unique case (rmode)
        RM_ARRAY:  sel = array_rdata;
        RM_IDENT:  sel = addr[0] ? DEV_ID : MFR_ID;
        RM_STATUS: sel = stat_word;
        RM_QUERY:  sel = query_word;
        default:   sel = stat_word;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_req;
      dout    <= rd_req ? sel : '0;
    end
  end

endmodule

// File: rtl/flash_cui.sv
module flash_cui
  import flash_cui_pkg::*;
#(
  parameter int              ADDR_W = 20,
  parameter int              DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h00C7,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h4A2E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              op_start,
  output logic              op_is_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata,
  input  logic              op_done,
  input  logic              op_fail,
  output logic              hold_prog,
  output logic              hold_erase
);

  logic              wr_evt;
  logic              rd_req;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  rd_mode_e          rmode;
  logic              busy;
  logic [7:0]        status;
  logic              setup_pend;
  logic              prog_run;
  logic              erase_run;

  cui_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .din      (din),
    .wr_evt   (wr_evt),
    .cap_addr (cap_addr),
    .cap_data (cap_data),
    .rd_req   (rd_req)
  );

  cui_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .wr_evt      (wr_evt),
    .cap_addr    (cap_addr),
    .cap_data    (cap_data),
    .op_done     (op_done),
    .op_fail     (op_fail),
    .rmode       (rmode),
    .busy        (busy),
    .status      (status),
    .setup_pend  (setup_pend),
    .prog_run    (prog_run),
    .erase_run   (erase_run),
    .op_start    (op_start),
    .op_is_erase (op_is_erase),
    .op_addr     (op_addr),
    .op_wdata    (op_wdata),
    .hold_prog   (hold_prog),
    .hold_erase  (hold_erase)
  );

  cui_read_mux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
  ) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd_req      (rd_req),
    .addr        (addr),
    .array_rdata (array_rdata),
    .rmode       (rmode),
    .busy        (busy),
    .status      (status),
    .dout        (dout),
    .dout_en     (dout_en)
  );

endmodule

// File: rtl/flash_cui_chk.sv
module flash_cui_chk
  import flash_cui_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ce_n,
  input logic       we_n,
  input logic       wr_evt,
  input logic [7:0] cmd,
  input logic       setup_pend,
  input rd_mode_e   rmode,
  input logic       busy,
  input logic       prog_run,
  input logic       erase_run,
  input logic [7:0] status,
  input logic       dout_en,
  input logic [7:0] dout_lo,
  input logic       op_start,
  input logic       hold_prog,
  input logic       hold_erase
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == STATUS_RESET && rmode == RM_ARRAY &&
                    !op_start && !hold_prog && !hold_erase && !dout_en));

  assert_no_drive_on_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !we_n) |=> !dout_en);

  assert_start_follows_write_R5: assert property (@(posedge clk) disable iff (rst)
    op_start |-> $past(wr_evt));

  assert_busy_reads_status_R7: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(busy)) |-> (dout_lo[7] == 1'b0));

  assert_suspend_by_command_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(hold_prog) || $rose(hold_erase)) |-> $past(wr_evt));

  assert_one_running_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_run, erase_run}));

  assert_unknown_keeps_mode_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !setup_pend && !cmd_known(cmd)) |=> $stable(rmode));

endmodule

bind flash_cui flash_cui_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce_n       (ce_n),
  .we_n       (we_n),
  .wr_evt     (wr_evt),
  .cmd        (cap_data[7:0]),
  .setup_pend (setup_pend),
  .rmode      (rmode),
  .busy       (busy),
  .prog_run   (prog_run),
  .erase_run  (erase_run),
  .status     (status),
  .dout_en    (dout_en),
  .dout_lo    (dout[7:0]),
  .op_start   (op_start),
  .hold_prog  (hold_prog),
  .hold_erase (hold_erase)
);

// File: tb/tb_flash_cui.sv
`timescale 1ns/1ps
module tb_flash_cui;

  localparam int          AW  = 20;
  localparam int          DW  = 16;
  localparam logic [15:0] MFR = 16'h00C7;
  localparam logic [15:0] DEV = 16'h4A2E;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          op_done = 1'b0, op_fail = 1'b0;
  logic [DW-1:0] array_rdata;
  logic [DW-1:0] dout;
  logic          dout_en, op_start, op_is_erase, hold_prog, hold_erase;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  function automatic logic [15:0] arr_fn(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction
  assign array_rdata = arr_fn(addr);

  always #2 clk = ~clk;

  flash_cui #(.ADDR_W(AW), .DATA_W(DW), .MFR_ID(MFR), .DEV_ID(DEV)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .array_rdata(array_rdata),
    .dout(dout), .dout_en(dout_en), .op_start(op_start),
    .op_is_erase(op_is_erase), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_done(op_done), .op_fail(op_fail),
    .hold_prog(hold_prog), .hold_erase(hold_erase)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: modes 0 array,1 ident,2 status,3 query;
  // phases 0 none,1 running,2 suspended; setup 0 none,1 prog,2 erase.
  int m_mode, m_setup, m_p, m_e;
  bit m_pe, m_ee, m_wphase, m_valid;
  logic [15:0] e_dout;
  logic [AW-1:0] e_oaddr;
  logic [15:0] e_owdata;
  bit e_den, e_start, e_kind, e_hp, e_he;

  function automatic logic [15:0] qtab(input logic [7:0] o);
    if (o == 8'h10) return 16'h0051;
    if (o == 8'h11) return 16'h0052;
    if (o == 8'h12) return 16'h0059;
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    int stat, op, oe;
    bit run, rd, evt;
    logic [7:0] c;
    if (rst) begin
      m_mode = 0; m_setup = 0; m_p = 0; m_e = 0; m_pe = 0; m_ee = 0;
      m_wphase = 0; e_den = 0; e_dout = 0; e_start = 0; e_kind = 0;
      e_oaddr = 0; e_owdata = 0; e_hp = 0; e_he = 0;
      m_valid = 1;
    end else begin
      op = m_p; oe = m_e;
      run = (op == 1) || (oe == 1);
      stat = (run ? 0 : 128) + (oe == 2 ? 64 : 0) + (m_ee ? 32 : 0) +
             (m_pe ? 16 : 0) + (op == 2 ? 4 : 0);
      rd = !ce_n && !oe_n && we_n;
      e_den = rd;
      if (!rd) e_dout = 0;
      else if (run || m_mode == 2) e_dout = stat[15:0];
      else if (m_mode == 0) e_dout = arr_fn(addr);
      else if (m_mode == 1) e_dout = addr[0] ? DEV : MFR;
      else e_dout = qtab(addr[7:0]);
      evt = m_wphase && (ce_n || we_n);
      m_wphase = !ce_n && !we_n && oe_n;
      e_start = 0;
      if (op_done && run) begin
        if (op == 1) begin m_p = 0; if (op_fail) m_pe = 1; end
        else begin m_e = 0; if (op_fail) m_ee = 1; end
      end
      if (evt) begin
        c = din[7:0];
        if (m_setup == 1) begin
          m_setup = 0; m_mode = 2; m_p = 1; e_start = 1; e_kind = 0;
          e_oaddr = addr; e_owdata = din;
        end else if (m_setup == 2) begin
          m_setup = 0; m_mode = 2;
          if (c == 8'hD0) begin
            m_e = 1; e_start = 1; e_kind = 1; e_oaddr = addr; e_owdata = din;
          end else begin m_pe = 1; m_ee = 1; end
        end else if (c == 8'hFF) m_mode = 0;
        else if (c == 8'h90) m_mode = 1;
        else if (c == 8'h70) m_mode = 2;
        else if (c == 8'h98) m_mode = 3;
        else if (c == 8'h50) begin m_pe = 0; m_ee = 0; end
        else if (c == 8'h40 || c == 8'h10) begin
          if (!run && op == 0) begin m_setup = 1; m_mode = 2; end
        end else if (c == 8'h20) begin
          if (!run && op == 0 && oe == 0) begin m_setup = 2; m_mode = 2; end
        end else if (c == 8'hB0) begin
          if (op == 1) begin m_p = 2; m_mode = 2; end
          else if (oe == 1) begin m_e = 2; m_mode = 2; end
        end else if (c == 8'hD0) begin
          if (op == 2) begin m_p = 1; m_mode = 2; end
          else if (oe == 2 && op == 0) begin m_e = 1; m_mode = 2; end
        end
      end
      e_hp = (m_p == 2);
      e_he = (m_e == 2);
    end
  end

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (m_valid) begin
      chk(dout_en === e_den, "R3 dout_en", 32'(dout_en), 32'(e_den));
      chk(dout === e_dout, "R4 dout", 32'(dout), 32'(e_dout));
      chk(op_start === e_start, "R5 op_start", 32'(op_start), 32'(e_start));
      chk(op_is_erase === e_kind, "R6 op_is_erase", 32'(op_is_erase), 32'(e_kind));
      chk(op_addr === e_oaddr, "R2 op_addr", 32'(op_addr), 32'(e_oaddr));
      chk(op_wdata === e_owdata, "R2 op_wdata", 32'(op_wdata), 32'(e_owdata));
      chk(hold_prog === e_hp, "R9 hold_prog", 32'(hold_prog), 32'(e_hp));
      chk(hold_erase === e_he, "R10 hold_erase", 32'(hold_erase), 32'(e_he));
    end
  end

  int n_starts = 0;
  logic [AW-1:0] s_addr;
  logic [15:0] s_data;
  bit s_er;
  always @(negedge clk) begin
    if (op_start === 1'b1) begin
      n_starts++; s_addr = op_addr; s_data = op_wdata; s_er = op_is_erase;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input bit ce_first);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
    @(negedge clk);
    @(negedge clk); if (ce_first) ce_n = 1; else we_n = 1;
    @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic cmdw(input logic [7:0] c);
    wr(20'h0ABCD, {8'h00, c}, 0);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk); v = dout;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic finish_op(input bit f);
    @(negedge clk); op_done = 1; op_fail = f;
    @(negedge clk); op_done = 0; op_fail = 0;
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
    logic [15:0] v;
    rd(a, v);
    chk(v === e, tag, 32'(v), 32'(e));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dout_en === 0 && op_start === 0 && hold_prog === 0 && hold_erase === 0,
        "R1 outputs in reset", 32'(dout_en), 0);
    rst = 0;
    @(negedge clk);
    expect_rd(20'h00005, arr_fn(20'h00005), "R1 array after reset");

    cmdw(8'h90);
    expect_rd(20'h00000, MFR, "R4 ident low");
    expect_rd(20'h00001, DEV, "R4 ident high");
    cmdw(8'h98);
    expect_rd(20'h00010, 16'h0051, "R4 query Q");
    expect_rd(20'h00012, 16'h0059, "R4 query Y");
    expect_rd(20'h00030, 16'h0000, "R4 query blank");
    cmdw(8'h70);
    expect_rd(20'h00000, 16'h0080, "R4 status");
    cmdw(8'h33);
    expect_rd(20'h00000, 16'h0080, "R11 unknown byte keeps mode");
    wr(20'h7FFFF, 16'h00FF, 0);
    expect_rd(20'h00123, arr_fn(20'h00123), "R11 any address carries command");

    // Strobes low with OE low: not a write.
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; din = 16'h0090;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; oe_n = 1;
    expect_rd(20'h00009, arr_fn(20'h00009), "R2 oe low pulse ignored");

    // Program, second cycle ended by CE first.
    cmdw(8'h40);
    wr(20'h00123, 16'hBEEF, 1);
    chk(n_starts == 1 && s_er == 0, "R5 program start", 32'(n_starts), 1);
    chk(s_addr == 20'h00123 && s_data == 16'hBEEF, "R2 captured on CE rise",
        32'(s_addr), 32'h123);
    expect_rd(20'h00000, 16'h0000, "R7 busy read");
    cmdw(8'h20);
    chk(n_starts == 1, "R7 setup ignored while busy", 32'(n_starts), 1);
    expect_rd(20'h00000, 16'h0000, "R7 still busy");
    finish_op(0);
    expect_rd(20'h00055, 16'h0080, "R8 done clears busy");
    expect_rd(20'h00055, 16'h0080, "R12 status until array cmd");
    cmdw(8'hFF);
    expect_rd(20'h00055, arr_fn(20'h00055), "R12 array after FF");

    cmdw(8'h40);
    wr(20'h00200, 16'h1111, 0);
    finish_op(1);
    expect_rd(20'h00000, 16'h0090, "R8 program fail bit");
    cmdw(8'h50);
    expect_rd(20'h00000, 16'h0080, "R8 clear status");

    // Erase with nested program suspension.
    cmdw(8'h20);
    wr(20'h04000, 16'h00D0, 0);
    chk(n_starts == 3 && s_er == 1 && s_addr == 20'h04000, "R6 erase start",
        32'(s_addr), 32'h4000);
    expect_rd(20'h00000, 16'h0000, "R7 erase busy");
    cmdw(8'hB0);
    chk(hold_erase === 1, "R9 erase held", 32'(hold_erase), 1);
    expect_rd(20'h00000, 16'h00C0, "R9 suspended status");
    cmdw(8'hFF);
    expect_rd(20'h00077, arr_fn(20'h00077), "R9 array read in suspend");
    cmdw(8'h40);
    wr(20'h00088, 16'h2222, 0);
    chk(n_starts == 4 && s_er == 0 && hold_erase === 1, "R10 nested program",
        32'(n_starts), 4);
    expect_rd(20'h00000, 16'h0040, "R10 nested busy");
    cmdw(8'hB0);
    chk(hold_prog === 1, "R10 program held", 32'(hold_prog), 1);
    expect_rd(20'h00000, 16'h00C4, "R10 both held");
    cmdw(8'h20);
    expect_rd(20'h00000, 16'h00C4, "R10 erase setup ignored");
    cmdw(8'hD0);
    chk(hold_prog === 0 && hold_erase === 1, "R10 inner resumes first",
        32'({hold_prog, hold_erase}), 1);
    expect_rd(20'h00000, 16'h0040, "R10 program resumed");
    finish_op(0);
    expect_rd(20'h00000, 16'h00C0, "R10 back to erase suspend");
    cmdw(8'hD0);
    chk(hold_erase === 0, "R9 erase resumed", 32'(hold_erase), 0);
    expect_rd(20'h00000, 16'h0000, "R9 erase running");
    finish_op(0);
    expect_rd(20'h00000, 16'h0080, "R8 erase done");

    cmdw(8'h20);
    cmdw(8'h11);
    chk(n_starts == 4, "R6 bad confirm starts nothing", 32'(n_starts), 4);
    expect_rd(20'h00000, 16'h00B0, "R6 sequence error bits");
    cmdw(8'h50);
    finish_op(1);
    expect_rd(20'h00000, 16'h0080, "R8 idle done ignored");

    repeat (4) @(negedge clk);
    summary();
  end

endmodule